// File: doc/BRIEF.md
# Two-Thread Partitioned Micro-Op Queue

This block is the buffer between a front end that produces decoded micro-ops for two hardware threads and a consumer that takes up to four of them per cycle. Each thread has its own write port. The storage is divided between the threads according to a thread mode. In dual mode each thread may hold half of the 56 entries. In a solo mode the running thread may hold all 56 entries and the halted thread holds none.

On the read side one thread is chosen per cycle. When both threads hold entries, the choice flips on every transfer so that neither thread starves. A thread that is alone on the read side gets every cycle. A halt or interrupt event does not change the mode at once. It is recorded as a request, and the change takes effect only once the whole queue is empty. This guarantees that no thread ever holds more entries than its new allowance.

The write ports and the read port use valid/ready handshakes. A write beat moves `in_cnt` entries when `in_valid` and `in_ready` are both high, and `in_ready` is the inverse of the thread's full flag. A read beat completes when `out_valid` and `out_ready` are both high. While `out_ready` is low the queue keeps its entries. The offered beat may still change if the other thread gains entries in the meantime.

Top module: `uopq_smt_part`

## Requirements
- R1: After reset the mode is dual, both threads are empty, `out_valid` is low, both full flags are low and both `in_ready` bits are high.
- R2: On a write beat for thread t (`in_valid[t] && in_ready[t]`), the first `in_cnt` lanes of that thread's data are appended in lane order, lane 0 first. `in_cnt` ranges from 0 to 4, and lane k occupies bits k*16 upward within the thread's slice. `in_ready[t]` equals the inverse of `full[t]`.
- R3: `full[t]` is high when the thread's allowance minus its occupancy is less than 4, or while a mode change is pending.
- R4: The allowance is 28 entries for each thread in dual mode. In solo mode for thread s it is 56 entries for thread s and 0 entries for the other thread.
- R5: When the selected thread holds n entries, the output offers min(n,4) entries, its oldest first on lane 0, with `out_cnt` equal to that number. With no eligible entries `out_valid` is low.
- R6: When both threads hold entries, the selected thread (`out_tid`, 0 or 1) is the opposite of the thread served by the last completed read beat. After reset, thread 0 is served first.
- R7: When only one thread holds entries, that thread is selected on every cycle.
- R8: In dual mode a halt on exactly one thread requests solo mode for the other thread. In solo mode an interrupt to the halted thread requests dual mode. All other halt and interrupt events are ignored: both threads at once, the running thread, or an event arriving while a request is pending.
- R9: A requested mode change takes effect on the first clock edge at which both threads are empty. Until then both full flags stay high.
- R10: A flush of thread t discards all of that thread's entries, drops that thread's write in the same cycle, and keeps that thread off the output in that cycle. The other thread's entries are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Write valid, bit t for thread t |
| in_cnt | input | 2*3 | Entries per write beat, 3 bits per thread |
| in_data | input | 2*4*16 | Write lanes, 64 bits per thread, lane 0 lowest |
| in_ready | output | 2 | Write ready per thread |
| halt | input | 2 | Halt event per thread |
| irq | input | 2 | Interrupt event per thread |
| flush | input | 2 | Per-thread discard |
| full | output | 2 | Per-thread full flag |
| out_valid | output | 1 | Read beat valid |
| out_ready | input | 1 | Consumer ready |
| out_tid | output | 1 | Thread of the offered beat |
| out_cnt | output | 3 | Entries in the offered beat |
| out_data | output | 4*16 | Offered lanes, oldest on lane 0 |

## Verification
The bench targets the allowance boundary. Six beats of four entries must leave a thread writable and the seventh must close it; in solo mode the limits are fourteen beats and zero. A wrong comparison shows up as a flag that rises one beat early or late. Mode changes are exercised against a queue that is still draining: a design that switches early would let a thread hold entries above its new limit, and one that forgot the pending state would keep accepting writes so the queue never empties. A flush that lands in the same cycle as a write and a pending read checks that only one thread is emptied and that no discarded entry ever appears on the output. A long pseudo-random sweep checks the ping-pong order, where a broken selector would serve one thread twice in a row or stall a lone thread.

// File: rtl/uopq_pkg.sv
package uopq_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL  = 2'd0,
    MODE_SOLO0 = 2'd1,
    MODE_SOLO1 = 2'd2
  } thr_mode_e;
endpackage

// File: rtl/uopq_thread_fifo.sv
// Per-thread circular store; occupancy is bounded externally by the allowance.
module uopq_thread_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 56,
  parameter int LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             wr_en,
  input  logic [$clog2(LANES+1)-1:0]       wr_cnt,
  input  logic [LANES*W-1:0]               wr_data,
  input  logic                             rd_en,
  input  logic [$clog2(LANES+1)-1:0]       rd_cnt,
  output logic [$clog2(DEPTH+1)-1:0]       occ,
  output logic [LANES*W-1:0]               rd_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH+1);
  localparam int unsigned DEPTH_U = DEPTH;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [OW-1:0] occ_q, wr_amt, rd_amt;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] base, input int unsigned step);
    int unsigned s;
    s = 32'(base) + step;
    if (s >= DEPTH_U) s = s - DEPTH_U;
    return PW'(s);
  endfunction

  assign wr_amt = (wr_en && !flush) ? OW'(wr_cnt) : '0;
  assign rd_amt = rd_en ? OW'(rd_cnt) : '0;

  always_ff @(posedge clk) begin
    for (int unsigned i = 0; i < LANES; i++) begin
      if (i < 32'(wr_amt)) mem[adv(wp, i)] <= wr_data[i*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      occ_q <= '0;
    end else if (flush) begin
      rp    <= wp;
      occ_q <= '0;
    end else begin
      rp    <= adv(rp, 32'(rd_amt));
      wp    <= adv(wp, 32'(wr_amt));
      occ_q <= occ_q + wr_amt - rd_amt;
    end
  end

  always_comb begin
    for (int unsigned i = 0; i < LANES; i++) begin
      rd_data[i*W +: W] = (i < 32'(occ_q)) ? mem[adv(rp, i)] : '0;
    end
  end

  assign occ = occ_q;
endmodule

// File: rtl/uopq_mode_ctl.sv
// Three-state thread mode machine with drain-gated transitions.
module uopq_mode_ctl
  import uopq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] halt,
  input  logic [1:0] irq,
  input  logic       q_empty,
  output thr_mode_e  mode,
  output logic       pending
);
  thr_mode_e mode_q, target_q, req_mode;
  logic      pend_q, req;

  always_comb begin
    req      = 1'b0;
    req_mode = mode_q;
    case (mode_q)
      MODE_DUAL: begin
        if (halt == 2'b01) begin
          req = 1'b1; req_mode = MODE_SOLO1;
        end else if (halt == 2'b10) begin
          req = 1'b1; req_mode = MODE_SOLO0;
        end
      end
      MODE_SOLO0: if (irq[1]) begin req = 1'b1; req_mode = MODE_DUAL; end
      MODE_SOLO1: if (irq[0]) begin req = 1'b1; req_mode = MODE_DUAL; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_DUAL;
      target_q <= MODE_DUAL;
      pend_q   <= 1'b0;
    end else if (pend_q) begin
      if (q_empty) begin
        mode_q <= target_q;
        pend_q <= 1'b0;
      end
    end else if (req) begin
      pend_q   <= 1'b1;
      target_q <= req_mode;
    end
  end

  assign mode    = mode_q;
  assign pending = pend_q;
endmodule

// File: rtl/uopq_rd_arb.sv
// Read-side thread selector: alternate when both eligible, else the lone one.
module uopq_rd_arb #(
  parameter int DEPTH = 56,
  parameter int LANES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(DEPTH+1)-1:0]   occ0,
  input  logic [$clog2(DEPTH+1)-1:0]   occ1,
  input  logic [1:0]                   flush,
  input  logic                         out_ready,
  output logic                         out_valid,
  output logic                         sel,
  output logic [$clog2(LANES+1)-1:0]   take_cnt,
  output logic [1:0]                   rd_en
);
  localparam int OW = $clog2(DEPTH+1);
  localparam int CW = $clog2(LANES+1);

  logic          has0, has1, last_q, xfer;
  logic [OW-1:0] avail;

  assign has0      = (occ0 != '0) && !flush[0];
  assign has1      = (occ1 != '0) && !flush[1];
  assign out_valid = has0 || has1;
  assign sel       = (has0 && has1) ? ~last_q : has1;
  assign avail     = sel ? occ1 : occ0;
  assign take_cnt  = (avail >= OW'(LANES)) ? CW'(LANES) : CW'(avail);
  assign xfer      = out_valid && out_ready;
  assign rd_en     = {xfer && sel, xfer && !sel};

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= 1'b1;
    else if (xfer) last_q <= sel;
  end
endmodule

// File: rtl/uopq_smt_part.sv
// Two-thread micro-op queue with mode-dependent partitioning.
module uopq_smt_part
  import uopq_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 56,
  parameter int LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       in_valid,
  input  logic [2*$clog2(LANES+1)-1:0]     in_cnt,
  input  logic [2*LANES*W-1:0]             in_data,
  output logic [1:0]                       in_ready,
  input  logic [1:0]                       halt,
  input  logic [1:0]                       irq,
  input  logic [1:0]                       flush,
  output logic [1:0]                       full,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic                             out_tid,
  output logic [$clog2(LANES+1)-1:0]       out_cnt,
  output logic [LANES*W-1:0]               out_data
);
  localparam int OW   = $clog2(DEPTH+1);
  localparam int CW   = $clog2(LANES+1);
  localparam int HALF = DEPTH / 2;

  thr_mode_e         mode_q;
  logic              mode_pend;
  logic [OW-1:0]     occ [2];
  logic [OW-1:0]     occ0, occ1;
  logic [LANES*W-1:0] rd_data [2];
  logic [1:0]        rd_en, full_w;
  logic [CW-1:0]     take_cnt;
  logic              sel;

  assign occ0 = occ[0];
  assign occ1 = occ[1];

  for (genvar t = 0; t < 2; t++) begin : g_thr
    localparam thr_mode_e OWN = (t == 0) ? MODE_SOLO0 : MODE_SOLO1;
    logic [OW-1:0] allow_t;
    logic          wr_en_t;

    assign allow_t = (mode_q == MODE_DUAL) ? OW'(HALF) :
                     (mode_q == OWN)       ? OW'(DEPTH) : '0;
    assign full_w[t] = mode_pend ||
                       (({1'b0, allow_t} - {1'b0, occ[t]}) < (OW+1)'(LANES));
    assign wr_en_t = in_valid[t] && !full_w[t];

    uopq_thread_fifo #(.W(W), .DEPTH(DEPTH), .LANES(LANES)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush[t]),
      .wr_en   (wr_en_t),
      .wr_cnt  (in_cnt[t*CW +: CW]),
      .wr_data (in_data[t*LANES*W +: LANES*W]),
      .rd_en   (rd_en[t]),
      .rd_cnt  (take_cnt),
      .occ     (occ[t]),
      .rd_data (rd_data[t])
    );
  end

  uopq_mode_ctl u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt    (halt),
    .irq     (irq),
    .q_empty ((occ0 == '0) && (occ1 == '0)),
    .mode    (mode_q),
    .pending (mode_pend)
  );

  uopq_rd_arb #(.DEPTH(DEPTH), .LANES(LANES)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ0      (occ0),
    .occ1      (occ1),
    .flush     (flush),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .sel       (sel),
    .take_cnt  (take_cnt),
    .rd_en     (rd_en)
  );

  assign full     = full_w;
  assign in_ready = ~full_w;
  assign out_tid  = sel;
  assign out_cnt  = take_cnt;
  assign out_data = sel ? rd_data[1] : rd_data[0];
endmodule

// File: rtl/uopq_smt_part_chk.sv
module uopq_smt_part_chk
  import uopq_pkg::*;
#(
  parameter int DEPTH = 56,
  parameter int LANES = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input thr_mode_e                    mode,
  input logic [$clog2(DEPTH+1)-1:0]   occ0,
  input logic [$clog2(DEPTH+1)-1:0]   occ1,
  input logic [1:0]                   flush,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic                         out_tid,
  input logic [$clog2(LANES+1)-1:0]   out_cnt
);
  localparam int OW = $clog2(DEPTH+1);
  localparam int CW = $clog2(LANES+1);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cnt != '0 && out_cnt <= CW'(LANES))); // R5
  AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (occ0 == '0 && occ1 == '0) |-> !out_valid); // R5
  AST_SOLO0_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SOLO0) |-> (occ1 == '0)); // R4
  AST_SOLO1_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SOLO1) |-> (occ0 == '0)); // R4
  AST_DUAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DUAL) |-> (occ0 <= OW'(DEPTH/2) && occ1 <= OW'(DEPTH/2))); // R4
  AST_MODE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ($past(occ0) == '0 && $past(occ1) == '0)); // R9
  AST_FLUSH0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush[0] |=> (occ0 == '0)); // R10
  AST_FLUSH1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush[1] |=> (occ1 == '0)); // R10
  AST_PING_TO1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_tid) |=> ((occ1 != '0 && !flush[1]) -> (out_valid && out_tid))); // R6
  AST_PING_TO0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_tid) |=> ((occ0 != '0 && !flush[0]) -> (out_valid && !out_tid))); // R6
endmodule

bind uopq_smt_part uopq_smt_part_chk #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode_q),
  .occ0      (occ0),
  .occ1      (occ1),
  .flush     (flush),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_tid   (out_tid),
  .out_cnt   (out_cnt)
);

// File: tb/uopq_smt_part_tb.sv
module uopq_smt_part_tb;
  localparam int W = 16, DEPTH = 56, LANES = 4, CW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst_n;
  logic [1:0]             in_valid, halt, irq, flush, in_ready, full;
  logic [2*CW-1:0]        in_cnt;
  logic [2*LANES*W-1:0]   in_data;
  logic                   out_valid, out_ready, out_tid;
  logic [CW-1:0]          out_cnt;
  logic [LANES*W-1:0]     out_data;

  uopq_smt_part #(.W(W), .DEPTH(DEPTH), .LANES(LANES)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cnt(in_cnt), .in_data(in_data),
    .in_ready(in_ready), .halt(halt), .irq(irq), .flush(flush), .full(full),
    .out_valid(out_valid), .out_ready(out_ready), .out_tid(out_tid),
    .out_cnt(out_cnt), .out_data(out_data));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model: mode 0 dual, 1 solo thread 0, 2 solo thread 1
  logic [W-1:0] qd [2][64];
  int qh [2], qn [2], seqn [2];
  int m_mode, m_pend, m_pmode, m_last;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int allow(input int t);
    if (m_mode == 0) return DEPTH / 2;
    if ((m_mode == 1 && t == 0) || (m_mode == 2 && t == 1)) return DEPTH;
    return 0;
  endfunction

  function automatic int efull(input int t);
    return (m_pend != 0 || (allow(t) - qn[t]) < LANES) ? 1 : 0;
  endfunction

  task automatic cyc(input bit [1:0] v, input int c0, input int c1, input bit [1:0] h,
                     input bit [1:0] i, input bit [1:0] f, input bit rdy);
    int has [2];
    int ev, es, ecnt, pre_empty, cnt [2], acc [2];
    @(negedge clk);
    cnt[0] = c0; cnt[1] = c1;
    in_valid = v; halt = h; irq = i; flush = f; out_ready = rdy;
    in_cnt = {CW'(c1), CW'(c0)};
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < LANES; k++)
        in_data[(t*LANES+k)*W +: W] = W'((t << 15) | ((seqn[t] + k) & 32'h7fff));
    #2;
    for (int t = 0; t < 2; t++) begin
      has[t] = (qn[t] > 0 && !f[t]) ? 1 : 0;
      acc[t] = (v[t] && efull(t) == 0) ? 1 : 0;
    end
    chk("R3 R4 R9", "full[0]", int'(full[0]), efull(0));
    chk("R3 R4 R9", "full[1]", int'(full[1]), efull(1));
    chk("R2", "in_ready", int'(in_ready), {30'd0, efull(1) == 0, efull(0) == 0});
    ev = has[0] | has[1];
    es = (has[0] != 0 && has[1] != 0) ? (m_last ^ 1) : has[1];
    chk("R5 R10", "out_valid", int'(out_valid), ev);
    ecnt = 0;
    if (ev != 0) begin
      ecnt = (qn[es] < LANES) ? qn[es] : LANES;
      chk("R6 R7", "out_tid", int'(out_tid), es);
      chk("R5", "out_cnt", int'(out_cnt), ecnt);
      for (int k = 0; k < ecnt; k++)
        chk("R2 R5", "lane", int'(out_data[k*W +: W]), int'(qd[es][(qh[es]+k) % 64]));
    end
    @(posedge clk);
    pre_empty = (qn[0] == 0 && qn[1] == 0) ? 1 : 0;
    for (int t = 0; t < 2; t++) begin
      if (f[t]) begin
        qh[t] = (qh[t] + qn[t]) % 64; qn[t] = 0;
      end else begin
        if (ev != 0 && rdy && es == t) begin
          qh[t] = (qh[t] + ecnt) % 64; qn[t] -= ecnt;
        end
        if (acc[t] != 0) begin
          for (int k = 0; k < cnt[t]; k++)
            qd[t][(qh[t] + qn[t] + k) % 64] = W'((t << 15) | ((seqn[t] + k) & 32'h7fff));
          qn[t] += cnt[t];
        end
      end
      if (acc[t] != 0 && !f[t]) seqn[t] += cnt[t];
    end
    if (ev != 0 && rdy) m_last = es;
    if (m_pend != 0) begin
      if (pre_empty != 0) begin m_mode = m_pmode; m_pend = 0; end
    end else begin
      if (m_mode == 0 && h == 2'b01) begin m_pend = 1; m_pmode = 2; end
      else if (m_mode == 0 && h == 2'b10) begin m_pend = 1; m_pmode = 1; end
      else if (m_mode == 1 && i[1]) begin m_pend = 1; m_pmode = 0; end
      else if (m_mode == 2 && i[0]) begin m_pend = 1; m_pmode = 0; end
    end
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int k = 0; k < n; k++) cyc(2'b00, 0, 0, 2'b00, 2'b00, 2'b00, rdy);
  endtask

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; in_valid = '0; in_cnt = '0; in_data = '0;
    halt = '0; irq = '0; flush = '0; out_ready = 1'b0;
    for (int t = 0; t < 2; t++) begin qh[t] = 0; qn[t] = 0; seqn[t] = 0; end
    m_mode = 0; m_pend = 0; m_pmode = 0; m_last = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "full after reset", int'(full), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 3);

    // fill to the dual-mode limit on each thread, then drain with ping-pong
    for (int k = 0; k < 8; k++) cyc(2'b01, 4, 0, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++) cyc(2'b10, 0, 4, 0, 0, 0, 0);
    idle(20, 1);
    // uneven counts, lone thread, flush colliding with write and read
    for (int k = 0; k < 5; k++) cyc(2'b11, k % 5, (k + 3) % 5, 0, 0, 0, 0);
    cyc(2'b11, 4, 4, 0, 0, 2'b01, 1);
    chk("R10", "thread 0 after flush", int'(full[0]), 0);
    idle(10, 1);

    // halt thread 1 while thread 0 holds entries
    for (int k = 0; k < 3; k++) cyc(2'b11, 4, 2, 0, 0, 0, 0);
    cyc(2'b00, 0, 0, 2'b10, 0, 0, 0);
    #1;
    chk("R8", "both full while pending", int'(full), 3);
    cyc(2'b11, 4, 4, 0, 0, 0, 0);
    idle(8, 1);
    for (int k = 0; k < 16; k++) cyc(2'b11, 4, 4, 0, 2'b01, 0, 0);
    cyc(2'b00, 0, 0, 0, 2'b10, 0, 0);
    idle(20, 1);
    // halt thread 0 and return
    cyc(2'b00, 0, 0, 2'b01, 0, 0, 1);
    idle(3, 1);
    for (int k = 0; k < 16; k++) cyc(2'b11, 3, 4, 2'b01, 2'b10, 0, 0);
    cyc(2'b00, 0, 0, 0, 2'b01, 0, 1);
    idle(25, 1);

    // pseudo-random sweep
    lf = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      bit [1:0] rv, rh, ri, rf;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      rv = lf[1:0];
      rh = (lf[12:8] == 5'd0) ? lf[14:13] : 2'b00;
      ri = (lf[19:16] == 4'd0) ? lf[21:20] : 2'b00;
      rf = (lf[27:23] == 5'd1) ? lf[29:28] : 2'b00;
      cyc(rv, int'(lf[4:2]) % 5, int'(lf[7:5]) % 5, rh, ri, rf, lf[31:30] != 2'b00);
    end
    idle(30, 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule